// File: doc/BRIEF.md
# PSRAM power-up and deep-standby sequencer

This block sits on the host side of a pseudo-static RAM. It takes the memory from power-on, or from deep standby, to the point where normal accesses are allowed. After power-good rises it holds chip select and the standby-mode pin high for a fixed settle interval. It then issues a fixed number of dummy reads, each one a low pulse on chip select with output enable and write enable held high and the data bus not driven. Only after that does it raise `ready_o`. Until then the block owns the memory control pins. Once `ready_o` is high, the pins pass straight through from the access controller.

When ready, a sleep request parks chip select high. After a programmable gap the block drops the mode pin, which puts the memory into deep standby, where its contents are lost. A wake request starts the whole settle-and-dummy-read sequence again. All interval lengths are clock counts set by parameters. At 250 MHz, the 200 µs settle interval is 50000 cycles.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset and whenever `pwr_good_i` is low (taking effect at the next clock edge), `ready_o` is 0, `mem_cs_n_o` is 1, `mem_mode_o` is 1, `mem_oe_n_o` and `mem_we_n_o` are 1, and `mem_dq_oe_o` is 0.
- R2: Power-good is first seen high at some clock edge. From then, `mem_cs_n_o` and `mem_mode_o` stay high for exactly `WAIT_CYCLES` cycles. The first chip-select low is then visible in cycle `WAIT_CYCLES+1` after that edge.
- R3: Exactly `NUM_DUMMY` dummy reads follow the wait. Each holds `mem_cs_n_o` low for `RD_LOW_CYCLES` cycles and then high for `RD_HIGH_CYCLES` cycles. `ready_o` rises in cycle `WAIT_CYCLES+1+NUM_DUMMY*(RD_LOW_CYCLES+RD_HIGH_CYCLES)`.
- R4: While `ready_o` is 0, the controller inputs have no effect. `mem_oe_n_o` and `mem_we_n_o` stay 1 and `mem_dq_oe_o` stays 0.
- R5: While `ready_o` is 1, `mem_cs_n_o`, `mem_oe_n_o`, `mem_we_n_o` and `mem_dq_oe_o` equal the matching controller inputs in the same cycle.
- R6: A sleep request seen at an edge while ready has these effects:
  - `ready_o` drops and `mem_cs_n_o` goes high in the next cycle.
  - `mem_mode_o` stays high for `PARK_CYCLES` cycles and then goes low.
  - `mem_mode_o` never falls unless chip select was already high in the cycle before.
- R7: In deep standby, `mem_mode_o` is 0 and `mem_cs_n_o` is 1. A wake request restarts the full sequence with the R2 and R3 timings counted from the edge that sees it.
- R8: Both requests are ignored while a settle or dummy-read sequence runs, so the ready time is unchanged. A wake request is ignored while ready, and a sleep request is ignored in deep standby.
- R9: Loss of power-good in any state gives the R1 pin state in the next cycle. When power-good returns, the full sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Memory supply is stable |
| sleep_req_i | input | 1 | Request entry into deep standby |
| wake_req_i | input | 1 | Request exit from deep standby |
| ctrl_cs_n_i | input | 1 | Controller chip select, active low |
| ctrl_oe_n_i | input | 1 | Controller output enable, active low |
| ctrl_we_n_i | input | 1 | Controller write enable, active low |
| ctrl_dq_oe_i | input | 1 | Controller drives the data bus |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write enable, active low |
| mem_mode_o | output | 1 | Memory standby-mode pin, low selects deep standby |
| mem_dq_oe_o | output | 1 | Host data bus driver enable |
| ready_o | output | 1 | Memory may be used by the controller |

## Verification
The bench builds the block with `WAIT_CYCLES=20`, `RD_LOW_CYCLES=3`, `RD_HIGH_CYCLES=2`, `PARK_CYCLES=2` and `NUM_DUMMY=3`. With these values a full power-up takes 36 cycles, so the run can cover several complete sequences: cold power-up, sleep followed by wake, and a power-good drop in the middle of a dummy read followed by a restart. The unequal low and high pulse widths, and a park gap longer than one cycle, let an off-by-one in any single timer or in the dummy-read count change an observable edge time.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_RD_LO,
    ST_RD_HI,
    ST_READY,
    ST_PARK,
    ST_DEEP
  } seq_state_e;

endpackage

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/psram_seq_fsm.sv
module psram_seq_fsm
  import psram_seq_pkg::*;
#(
  parameter int WAIT_CYCLES    = 50000,
  parameter int RD_LOW_CYCLES  = 20,
  parameter int RD_HIGH_CYCLES = 4,
  parameter int PARK_CYCLES    = 2,
  parameter int NUM_DUMMY      = 3,
  parameter int TW             = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_good_i,
  input  logic          sleep_req_i,
  input  logic          wake_req_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output seq_state_e    state_o
);

  localparam int RW = $clog2(NUM_DUMMY + 1);
  localparam logic [RW-1:0] RD_LAST = RW'(NUM_DUMMY - 1);
  localparam logic [TW-1:0] V_WAIT  = TW'(WAIT_CYCLES - 1);
  localparam logic [TW-1:0] V_LO    = TW'(RD_LOW_CYCLES - 1);
  localparam logic [TW-1:0] V_HI    = TW'(RD_HIGH_CYCLES - 1);
  localparam logic [TW-1:0] V_PARK  = TW'(PARK_CYCLES - 1);

  seq_state_e    state_q, state_d;
  logic [RW-1:0] rd_q, rd_d;

  always_comb begin
    state_d    = state_q;
    rd_d       = rd_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (!pwr_good_i) begin
      state_d = ST_OFF;
      rd_d    = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = V_WAIT;
          rd_d       = '0;
        end
        ST_WAIT: if (tmr_zero_i) begin
          state_d    = ST_RD_LO;
          tmr_load_o = 1'b1;
          tmr_val_o  = V_LO;
        end
        ST_RD_LO: if (tmr_zero_i) begin
          state_d    = ST_RD_HI;
          tmr_load_o = 1'b1;
          tmr_val_o  = V_HI;
        end
        ST_RD_HI: if (tmr_zero_i) begin
          if (rd_q == RD_LAST) begin
            state_d = ST_READY;
            rd_d    = '0;
          end else begin
            state_d    = ST_RD_LO;
            rd_d       = rd_q + 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = V_LO;
          end
        end
        ST_READY: if (sleep_req_i) begin
          state_d    = ST_PARK;
          tmr_load_o = 1'b1;
          tmr_val_o  = V_PARK;
        end
        ST_PARK: if (tmr_zero_i) state_d = ST_DEEP;
        ST_DEEP: if (wake_req_i) begin
          state_d    = ST_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = V_WAIT;
          rd_d       = '0;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/psram_seq_pins.sv
module psram_seq_pins
  import psram_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       ctrl_cs_n_i,
  input  logic       ctrl_oe_n_i,
  input  logic       ctrl_we_n_i,
  input  logic       ctrl_dq_oe_i,
  output logic       mem_cs_n_o,
  output logic       mem_oe_n_o,
  output logic       mem_we_n_o,
  output logic       mem_mode_o,
  output logic       mem_dq_oe_o,
  output logic       ready_o
);

  logic own_n;

  assign own_n       = (state_i == ST_READY);
  assign ready_o     = own_n;
  assign mem_cs_n_o  = own_n ? ctrl_cs_n_i : (state_i != ST_RD_LO);
  assign mem_oe_n_o  = own_n ? ctrl_oe_n_i : 1'b1;
  assign mem_we_n_o  = own_n ? ctrl_we_n_i : 1'b1;
  assign mem_dq_oe_o = own_n & ctrl_dq_oe_i;
  assign mem_mode_o  = (state_i != ST_DEEP);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int WAIT_CYCLES    = 50000,
  parameter int RD_LOW_CYCLES  = 20,
  parameter int RD_HIGH_CYCLES = 4,
  parameter int PARK_CYCLES    = 2,
  parameter int NUM_DUMMY      = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic ctrl_cs_n_i,
  input  logic ctrl_oe_n_i,
  input  logic ctrl_we_n_i,
  input  logic ctrl_dq_oe_i,
  output logic mem_cs_n_o,
  output logic mem_oe_n_o,
  output logic mem_we_n_o,
  output logic mem_mode_o,
  output logic mem_dq_oe_o,
  output logic ready_o
);

  localparam int MAX_RD = (RD_LOW_CYCLES > RD_HIGH_CYCLES) ? RD_LOW_CYCLES : RD_HIGH_CYCLES;
  localparam int MAX_A  = (WAIT_CYCLES > PARK_CYCLES) ? WAIT_CYCLES : PARK_CYCLES;
  localparam int MAX_C  = (MAX_A > MAX_RD) ? MAX_A : MAX_RD;
  localparam int TW     = $clog2(MAX_C + 1);

  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  seq_state_e    state;

  psram_seq_timer #(.TW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  psram_seq_fsm #(
    .WAIT_CYCLES    (WAIT_CYCLES),
    .RD_LOW_CYCLES  (RD_LOW_CYCLES),
    .RD_HIGH_CYCLES (RD_HIGH_CYCLES),
    .PARK_CYCLES    (PARK_CYCLES),
    .NUM_DUMMY      (NUM_DUMMY),
    .TW             (TW)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .tmr_zero_i  (tmr_zero),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .state_o     (state)
  );

  psram_seq_pins u_pins (
    .state_i      (state),
    .ctrl_cs_n_i  (ctrl_cs_n_i),
    .ctrl_oe_n_i  (ctrl_oe_n_i),
    .ctrl_we_n_i  (ctrl_we_n_i),
    .ctrl_dq_oe_i (ctrl_dq_oe_i),
    .mem_cs_n_o   (mem_cs_n_o),
    .mem_oe_n_o   (mem_oe_n_o),
    .mem_we_n_o   (mem_we_n_o),
    .mem_mode_o   (mem_mode_o),
    .mem_dq_oe_o  (mem_dq_oe_o),
    .ready_o      (ready_o)
  );

endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int NUM_DUMMY = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic sleep_req_i,
  input logic mem_cs_n_o,
  input logic mem_oe_n_o,
  input logic mem_we_n_o,
  input logic mem_mode_o,
  input logic mem_dq_oe_o,
  input logic ready_o
);

  localparam int FW = $clog2(NUM_DUMMY + 2);

  logic          cs_prev_q;
  logic [FW-1:0] falls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b1;
      falls_q   <= '0;
    end else begin
      cs_prev_q <= mem_cs_n_o;
      if (ready_o || !mem_mode_o || !pwr_good_i)        falls_q <= '0;
      else if (cs_prev_q && !mem_cs_n_o && falls_q != '1) falls_q <= falls_q + 1'b1;
    end
  end

  a_r1_power_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (!ready_o && mem_cs_n_o && mem_mode_o));

  a_r4_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  a_r3_dummy_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (falls_q == FW'(NUM_DUMMY)));

  a_r6_cs_before_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_mode_o) |-> (mem_cs_n_o && $past(mem_cs_n_o)));

  a_r6_sleep_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sleep_req_i && pwr_good_i) |=> (!ready_o && mem_mode_o && mem_cs_n_o));

  a_r7_deep_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_mode_o |-> (mem_cs_n_o && !ready_o));

  a_r8_stay_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !sleep_req_i && pwr_good_i) |=> ready_o);

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(.NUM_DUMMY(NUM_DUMMY)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_good_i  (pwr_good_i),
  .sleep_req_i (sleep_req_i),
  .mem_cs_n_o  (mem_cs_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_mode_o  (mem_mode_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .ready_o     (ready_o)
);

// File: tb/sim_psram_pwr_seq.sv
`timescale 1ns/1ps
module sim_psram_pwr_seq;

  localparam int W    = 20;
  localparam int LO   = 3;
  localparam int HI   = 2;
  localparam int PARK = 2;
  localparam int N    = 3;
  localparam int PER  = LO + HI;
  localparam int T_RDY = W + 1 + N * PER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic c_cs_n = 1'b1, c_oe_n = 1'b1, c_we_n = 1'b1, c_dq_oe = 1'b0;
  logic m_cs_n, m_oe_n, m_we_n, m_mode, m_dq_oe, ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psram_pwr_seq #(
    .WAIT_CYCLES(W), .RD_LOW_CYCLES(LO), .RD_HIGH_CYCLES(HI),
    .PARK_CYCLES(PARK), .NUM_DUMMY(N)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good),
    .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .ctrl_cs_n_i(c_cs_n), .ctrl_oe_n_i(c_oe_n), .ctrl_we_n_i(c_we_n), .ctrl_dq_oe_i(c_dq_oe),
    .mem_cs_n_o(m_cs_n), .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n),
    .mem_mode_o(m_mode), .mem_dq_oe_o(m_dq_oe), .ready_o(ready)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: 0 off, 1 sequence, 2 ready, 3 park, 4 deep
  int m = 0, k = 0, j = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m = 0;
    else if (!pwr_good) m = 0;
    else case (m)
      0: begin m = 1; k = 0; end
      1: begin k++; if (k == W + N * PER) m = 2; end
      2: if (sleep_req) begin m = 3; j = 0; end
      3: begin j++; if (j == PARK) m = 4; end
      4: if (wake_req) begin m = 1; k = 0; end
      default: m = 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_cs;
      if (m == 2) e_cs = c_cs_n;
      else if (m == 1 && k >= W && ((k - W) % PER) < LO) e_cs = 0;
      else e_cs = 1;
      chk("R3", "cs_n", m_cs_n, e_cs);
      chk("R6", "mode", m_mode, (m == 4) ? 0 : 1);
      chk("R3", "ready", ready, (m == 2) ? 1 : 0);
      chk((m == 2) ? "R5" : "R4", "oe_n", m_oe_n, (m == 2) ? c_oe_n : 1);
      chk((m == 2) ? "R5" : "R4", "we_n", m_we_n, (m == 2) ? c_we_n : 1);
      chk((m == 2) ? "R5" : "R4", "dq_oe", m_dq_oe, (m == 2) ? c_dq_oe : 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // counts negedges until ready; poke toggles requests mid-sequence
  task automatic measure(input bit poke, output int t_cs, output int t_rdy);
    t_cs = -1; t_rdy = -1;
    for (int n = 1; n < 2000; n++) begin
      @(negedge clk);
      if (t_cs < 0 && !m_cs_n) t_cs = n;
      if (n == 2) begin
        chk("R4", "oe_n in sequence", m_oe_n, 1);
        chk("R4", "dq_oe in sequence", m_dq_oe, 0);
      end
      if (poke && n == 5)     begin sleep_req = 1; wake_req = 1; end
      if (poke && n == 8)     begin sleep_req = 0; wake_req = 0; end
      if (poke && n == W + 3) sleep_req = 1;
      if (poke && n == W + 6) sleep_req = 0;
      if (ready) begin t_rdy = n; break; end
    end
  endtask

  initial begin
    int tc, tr;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", ready, 0);
    chk("R1", "cs_n in reset", m_cs_n, 1);
    chk("R1", "mode in reset", m_mode, 1);
    tick(); rst_n = 1'b1;
    repeat (3) tick();
    @(negedge clk);
    chk("R1", "cs_n unpowered", m_cs_n, 1);

    // aggressive controller levels during sequence must not reach the pins
    tick(); c_cs_n = 0; c_oe_n = 0; c_we_n = 0; c_dq_oe = 1; pwr_good = 1;
    tick();
    measure(1'b0, tc, tr);
    chk("R2", "first cs low cycle", tc, W + 1);
    chk("R3", "ready cycle", tr, T_RDY);
    #1;
    chk("R5", "cs_n passthrough", m_cs_n, 0);
    chk("R5", "we_n passthrough", m_we_n, 0);
    chk("R5", "dq_oe passthrough", m_dq_oe, 1);
    tick(); c_cs_n = 1; c_oe_n = 1; c_we_n = 1; c_dq_oe = 0;

    tick(); wake_req = 1;
    repeat (3) tick();
    wake_req = 0;
    @(negedge clk);
    chk("R8", "ready after wake while ready", ready, 1);

    tick(); sleep_req = 1;
    tick(); sleep_req = 0;
    tr = -1;
    for (int n = 1; n < 50; n++) begin
      @(negedge clk);
      if (n == 1) begin
        chk("R6", "ready after sleep", ready, 0);
        chk("R6", "cs_n after sleep", m_cs_n, 1);
      end
      if (!m_mode) begin tr = n; break; end
    end
    chk("R6", "mode low cycle", tr, PARK + 1);

    tick(); sleep_req = 1;
    repeat (3) tick();
    sleep_req = 0;
    @(negedge clk);
    chk("R8", "mode after sleep in deep", m_mode, 0);
    chk("R7", "cs_n in deep", m_cs_n, 1);

    tick(); wake_req = 1;
    tick(); wake_req = 0;
    measure(1'b1, tc, tr);
    chk("R7", "wake first cs low", tc, W + 1);
    chk("R8", "wake ready with ignored requests", tr, T_RDY);

    // power loss in the middle of a dummy read
    tick(); pwr_good = 0;
    tick();
    @(negedge clk);
    chk("R9", "ready after loss", ready, 0);
    tick(); pwr_good = 1;
    tick();
    repeat (W + 1) @(negedge clk);
    chk("R3", "cs low in first dummy read", m_cs_n, 0);
    tick(); pwr_good = 0;
    tick();
    @(negedge clk);
    chk("R9", "cs_n after loss mid-read", m_cs_n, 1);
    chk("R9", "mode after loss mid-read", m_mode, 1);
    tick(); pwr_good = 1;
    tick();
    measure(1'b0, tc, tr);
    chk("R9", "ready after restore", tr, T_RDY);

    repeat (2) tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R3 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule